// File: doc/BRIEF.md
# Reset Generation Unit with Pulse and Held Lines

This block drives a bank of individual reset lines from a small register bus. Software starts a reset on any line by writing a 1 into that line's bit of a control word. Most lines then run a self-terminating pulse of a fixed, parameterised number of clock cycles and release on their own. A few designated lines are instead held asserted until software writes a 0 into their control bit. Line 0 also drives a dedicated whole-system reset request output.

Software can observe the lines in two ways. The control words read back the live state of each line, with 1 meaning asserted. The status words read back the inverse, so a 0 there marks a line that is still in reset. Every bus access is answered one cycle later with a ready strobe, and read data arrives with that strobe.

Top module: `rstgen_unit`

## Requirements
- R1: With default parameters there are 64 lines. Control word 0 at byte offset 0x100 holds lines 0..31, and control word 1 at 0x104 holds lines 32..63, with bit b of word w mapping to line 32*w+b. Writing 1 to a bit asserts that line, and `rst_lines` shows it after the writing clock edge.
- R2: Status words at 0x150 (lines 0..31) and 0x154 (lines 32..63) use the same bit mapping and read 0 for an active line and 1 for a released one.
- R3: A control word reads back the current line state, 1 for asserted.
- R4: A non-held line stays asserted for exactly PULSE_LEN clock cycles after the write and then releases with no further write.
- R5: Writing 1 again to a non-held line while its pulse runs restarts the pulse, so it lasts a full PULSE_LEN cycles from the latest write.
- R6: Writing 0 to the bit of a non-held line has no effect on that line, and its running pulse ends at its original time.
- R7: The held lines are 12 and 56 by default (bit positions set in STICKY_MASK). A held line stays asserted until a write to its control word carries 0 in its bit, and it is released after that clock edge.
- R8: `sys_reset_req` is high exactly while line 0 is asserted.
- R9: Writes to any offset other than the two control words change no line. Reads from any offset other than the four defined words return 0.
- R10: `bus_ready` pulses high for one cycle in the cycle after each cycle in which `bus_sel` is high, and `bus_rdata` carries the read result in that cycle.
- R11: While `rst` is high, all lines and `sys_reset_req` are released. Afterwards both status words read all ones and both control words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the unit |
| bus_sel | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W (12) | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completion strobe |
| rst_lines | output | NUM_LINES (64) | Reset lines, 1 = asserted |
| sys_reset_req | output | 1 | Whole-system reset request, follows line 0 |

## Verification
The bench builds the unit with PULSE_LEN set to 6 and keeps the default line count and held-line mask. The short pulse lets the bench check every cycle of a pulse, including its restart and its unchanged end after an ignored 0-write, within a few cycles. The default mask leaves both held lines, one in each control word, where the bench can drive them. With 64 lines both word decodes and both status words are exercised.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  localparam int unsigned WORD_BITS = 32;
  localparam int unsigned WORD_BYTES = 4;

  function automatic int unsigned word_of(input int unsigned line);
    return line / WORD_BITS;
  endfunction

  function automatic int unsigned bit_of(input int unsigned line);
    return line % WORD_BITS;
  endfunction
endpackage

// File: rtl/rstgen_regif.sv
// Register decode: per-word write strobes and a registered read mux.
module rstgen_regif #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned WORDS     = 2,
  parameter int unsigned CTRL_BASE = 'h100,
  parameter int unsigned STAT_BASE = 'h150
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  bus_sel,
  input  logic                                  bus_we,
  input  logic [ADDR_W-1:0]                     bus_addr,
  input  logic [WORDS*rstgen_pkg::WORD_BITS-1:0] line_state,
  output logic [WORDS-1:0]                      wr_word,
  output logic [rstgen_pkg::WORD_BITS-1:0]      bus_rdata,
  output logic                                  bus_ready
);
  import rstgen_pkg::*;

  logic [WORD_BITS-1:0] rd_next;

  for (genvar w = 0; w < WORDS; w++) begin : g_wdec
    localparam logic [ADDR_W-1:0] CtrlAddr = ADDR_W'(CTRL_BASE + WORD_BYTES * w);
    assign wr_word[w] = bus_sel && bus_we && (bus_addr == CtrlAddr);
  end

  always_comb begin
    rd_next = '0;
    for (int w = 0; w < int'(WORDS); w++) begin
      if (bus_addr == ADDR_W'(CTRL_BASE + WORD_BYTES * w))
        rd_next = line_state[w*WORD_BITS +: WORD_BITS];
      if (bus_addr == ADDR_W'(STAT_BASE + WORD_BYTES * w))
        rd_next = ~line_state[w*WORD_BITS +: WORD_BITS];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_sel;
      bus_rdata <= (bus_sel && !bus_we) ? rd_next : '0;
    end
  end
endmodule

// File: rtl/rstgen_pulse_line.sv
// Self-terminating reset line: active for PULSE_LEN cycles after each set.
module rstgen_pulse_line #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  output logic line_o
);
  localparam int unsigned CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CNT_W-1:0] Reload = CNT_W'(PULSE_LEN - 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_o <= 1'b0;
      remain <= '0;
    end else if (set_i) begin
      line_o <= 1'b1;
      remain <= Reload;
    end else if (line_o) begin
      if (remain == '0) line_o <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/rstgen_sticky_line.sv
// Held reset line: set by a 1 write, cleared only by a 0 write.
module rstgen_sticky_line (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic line_o
);
  always_ff @(posedge clk) begin
    if (rst)        line_o <= 1'b0;
    else if (set_i) line_o <= 1'b1;
    else if (clr_i) line_o <= 1'b0;
  end
endmodule

// File: rtl/rstgen_unit.sv
module rstgen_unit #(
  parameter int unsigned          NUM_LINES   = 64,
  parameter int unsigned          PULSE_LEN   = 16,
  parameter int unsigned          ADDR_W      = 12,
  parameter int unsigned          CTRL_BASE   = 'h100,
  parameter int unsigned          STAT_BASE   = 'h150,
  parameter logic [NUM_LINES-1:0] STICKY_MASK = 64'h0100_0000_0000_1000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_ready,
  output logic [NUM_LINES-1:0] rst_lines,
  output logic                 sys_reset_req
);
  import rstgen_pkg::*;

  localparam int unsigned WORDS = NUM_LINES / WORD_BITS;

  logic [WORDS-1:0] wr_word;

  rstgen_regif #(
    .ADDR_W   (ADDR_W),
    .WORDS    (WORDS),
    .CTRL_BASE(CTRL_BASE),
    .STAT_BASE(STAT_BASE)
  ) regif_i (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .line_state(rst_lines),
    .wr_word   (wr_word),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int unsigned W = word_of(i);
    localparam int unsigned B = bit_of(i);
    logic set_l;
    assign set_l = wr_word[W] && bus_wdata[B];

    if (STICKY_MASK[i]) begin : g_held
      logic clr_l;
      assign clr_l = wr_word[W] && !bus_wdata[B];
      rstgen_sticky_line line_i (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_l),
        .clr_i (clr_l),
        .line_o(rst_lines[i])
      );
    end else begin : g_pulse
      rstgen_pulse_line #(.PULSE_LEN(PULSE_LEN)) line_i (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_l),
        .line_o(rst_lines[i])
      );
    end
  end

  // Line 0 requests a whole-system reset.
  assign sys_reset_req = rst_lines[0];
endmodule

// File: rtl/rstgen_checker.sv
module rstgen_checker #(
  parameter int unsigned          NUM_LINES   = 64,
  parameter int unsigned          ADDR_W      = 12,
  parameter int unsigned          CTRL_BASE   = 'h100,
  parameter int unsigned          STAT_BASE   = 'h150,
  parameter logic [NUM_LINES-1:0] STICKY_MASK = '0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_sel,
  input logic                 bus_we,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic                 bus_ready,
  input logic [NUM_LINES-1:0] rst_lines,
  input logic                 sys_reset_req
);
  localparam logic [ADDR_W-1:0] Ctrl0 = ADDR_W'(CTRL_BASE);
  localparam logic [ADDR_W-1:0] Stat0 = ADDR_W'(STAT_BASE);

  // R10: ready follows every access by one cycle
  a_r10_ready_follows: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (bus_ready == $past(bus_sel)));

  // R2: status word 0 reads the inverse of lines 0..31
  a_r2_status_inverted: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(bus_sel && !bus_we && bus_addr == Stat0))
      |-> (bus_rdata == ~$past(rst_lines[31:0])));

  // R8: system request rises only on a 1 written to bit 0 of control word 0
  a_r8_sys_from_line0: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_reset_req) |-> $past(bus_sel && bus_we && bus_addr == Ctrl0 && bus_wdata[0]));

  // R11: lines released after the unit's reset
  a_r11_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (rst_lines == '0 && !sys_reset_req));

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
    localparam logic [ADDR_W-1:0] WAddr = ADDR_W'(CTRL_BASE + 4 * (i / 32));
    localparam int unsigned B = i % 32;

    // R1/R9: a line rises only on a 1 written to its own control bit
    a_r1_rise_needs_write: assert property (@(posedge clk) disable iff (rst)
      $rose(rst_lines[i]) |-> $past(bus_sel && bus_we && bus_addr == WAddr && bus_wdata[B]));

    if (STICKY_MASK[i]) begin : g_held
      // R7: a held line stays up unless its bit was written with 0
      a_r7_held_line: assert property (@(posedge clk) disable iff (rst)
        ($past(rst_lines[i]) && !$past(bus_sel && bus_we && bus_addr == WAddr && !bus_wdata[B]))
          |-> rst_lines[i]);
    end
  end
endmodule

bind rstgen_unit rstgen_checker #(
  .NUM_LINES  (NUM_LINES),
  .ADDR_W     (ADDR_W),
  .CTRL_BASE  (CTRL_BASE),
  .STAT_BASE  (STAT_BASE),
  .STICKY_MASK(STICKY_MASK)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .bus_sel      (bus_sel),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .bus_ready    (bus_ready),
  .rst_lines    (rst_lines),
  .sys_reset_req(sys_reset_req)
);

// File: tb/rstgen_unit_tb_top.sv
module rstgen_unit_tb_top;
  localparam int PL = 6;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_sel;
  logic        bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [63:0] rst_lines;
  logic        sys_reset_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  rstgen_unit #(.PULSE_LEN(PL)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .rst_lines(rst_lines), .sys_reset_req(sys_reset_req)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_lines(input string req, input logic [63:0] exp);
    check(rst_lines === exp, req, rst_lines, exp);
  endtask

  // All bus tasks start and end just after a falling edge.
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d,
                          output logic rdy);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; rdy = bus_ready;
    bus_sel = 1'b0;
  endtask

  task automatic read_check(input string req, input logic [11:0] a,
                            input logic [31:0] exp);
    logic [31:0] d;
    logic rdy;
    bus_read(a, d, rdy);
    check(rdy === 1'b1, "R10 ready", 64'(rdy), 64'd1);
    check(d === exp, req, 64'(d), 64'(exp));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    check_lines("R11 lines after reset", 64'd0);
    check(sys_reset_req === 1'b0, "R11 sys req", 64'(sys_reset_req), 64'd0);
    check(bus_ready === 1'b0, "R10 idle ready", 64'(bus_ready), 64'd0);
    read_check("R11/R2 status0 ones", 12'h150, 32'hFFFF_FFFF);
    read_check("R11/R2 status1 ones", 12'h154, 32'hFFFF_FFFF);
    read_check("R11/R3 ctrl0 zero", 12'h100, 32'd0);
  endtask

  task automatic t_pulse;
    bus_write(12'h104, 32'h0000_0008);  // line 35
    for (int k = 0; k < PL; k++) begin
      check_lines("R1/R4 pulse high", 64'd1 << 35);
      @(negedge clk);
    end
    check_lines("R4 pulse released", 64'd0);
  endtask

  task automatic t_readback;
    bus_write(12'h100, 32'h0000_0020);  // line 5
    read_check("R2 status0 active bit", 12'h150, ~32'h0000_0020);
    read_check("R3 ctrl0 active bit", 12'h100, 32'h0000_0020);
    bus_write(12'h104, 32'h8000_0000);  // line 63
    read_check("R2 status1 active bit", 12'h154, ~32'h8000_0000);
    read_check("R3 ctrl1 active bit", 12'h104, 32'h8000_0000);
    idle(PL);
    check_lines("R4 readback lines released", 64'd0);
  endtask

  task automatic t_restart;
    bus_write(12'h100, 32'h0000_0002);  // line 1
    idle(3);
    bus_write(12'h100, 32'h0000_0002);
    for (int k = 0; k < PL; k++) begin
      check_lines("R5 restarted pulse high", 64'd2);
      @(negedge clk);
    end
    check_lines("R5 restarted pulse released", 64'd0);
  endtask

  task automatic t_zero_ignored;
    bus_write(12'h100, 32'h0000_0080);  // line 7
    bus_write(12'h100, 32'h0000_0000);
    for (int k = 0; k < PL - 1; k++) begin
      check_lines("R6 zero write ignored", 64'd1 << 7);
      @(negedge clk);
    end
    check_lines("R6 original end kept", 64'd0);
  endtask

  task automatic t_held;
    bus_write(12'h100, 32'h0000_1000);  // line 12
    bus_write(12'h104, 32'h0100_0000);  // line 56
    idle(3 * PL);
    check_lines("R7 held lines stay", (64'd1 << 12) | (64'd1 << 56));
    read_check("R7/R2 held status0", 12'h150, ~32'h0000_1000);
    bus_write(12'h100, 32'h0000_0000);
    check_lines("R7 line 12 released", 64'd1 << 56);
    bus_write(12'h104, 32'h0000_0000);
    check_lines("R7 line 56 released", 64'd0);
  endtask

  task automatic t_sys;
    bus_write(12'h100, 32'h0000_0001);
    check(sys_reset_req === 1'b1, "R8 sys req on", 64'(sys_reset_req), 64'd1);
    idle(PL);
    check(sys_reset_req === 1'b0, "R8 sys req off", 64'(sys_reset_req), 64'd0);
  endtask

  task automatic t_undefined;
    bus_write(12'h108, 32'hFFFF_FFFF);
    bus_write(12'h150, 32'hFFFF_FFFF);
    bus_write(12'h000, 32'hFFFF_FFFF);
    check_lines("R9 undefined writes ignored", 64'd0);
    read_check("R9 read 0x108", 12'h108, 32'd0);
    read_check("R9 read 0x000", 12'h000, 32'd0);
  endtask

  initial begin
    rst = 1'b1; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pulse();
    t_readback();
    t_restart();
    t_zero_ignored();
    t_held();
    t_sys();
    t_undefined();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule